// File: doc/BRIEF.md
# Extended-range one-shot delay scheduler

This block turns a one-shot delay request into a series of comparator arms, so that delays far longer than the comparator's reach still complete on time. A free-running microsecond reference `now_i` comes in from outside. A request is first reduced by a fixed correction and floored at zero. The result is then split into a number of full-range chunks (the bits above the comparator width) and a remainder (the low bits). Each chunk arms the comparator for the largest interval it can hold. The remainder is armed last. When the final interval expires, a one-cycle completion pulse is produced.

The time base can be paused and resumed. A pause takes the time that has passed since the delay was launched off the pending delay. A resume launches the reduced delay again, with no second correction. A pending delay can be cancelled, or replaced by a newer request. A request may carry a relative delay or an absolute target time; an absolute target is turned into a relative delay against `now_i`. All time arithmetic wraps modulo 2^TW.

When several commands arrive in the same cycle, the highest one in this order wins: cancel, pause, resume, relative request, absolute request, comparator hit.

Top module: `dly_sched`

## Requirements
- R1: After reset `fire_o`, `busy_o` and `armed_o` are 0 and `cmp_target_o` is 0; the time base is paused.
- R2: A new request delay D becomes D-CORR when D > CORR and 0 otherwise.
- R3: A corrected delay d yields n = d >> CW full chunks and r = d mod 2^CW. Each chunk arms the comparator for MAXI = 2^CW-1 microseconds, one chunk after another.
- R4: With n > 0, once the chunks are spent, a remainder r >= MIN is armed as a final interval. A remainder r < MIN is dropped, and completion comes at the end of the last chunk.
- R5: With n = 0, a remainder r > MIN is armed directly. Otherwise the comparator is armed for MIN, so a corrected delay of 0..MIN completes after MIN.
- R6: On completion, `fire_o` is high for exactly one cycle, in the cycle after the edge where `now_i` reaches the armed target. In that same cycle `busy_o` and `armed_o` are 0 and `cmp_target_o` is 0.
- R7: An absolute request with value V is handled as a relative request with delay V - now_i (mod 2^TW).
- R8: A request made while paused sets `busy_o` but does not arm. The resume command arms it, and timing starts at the resume edge. Resume with nothing pending leaves `armed_o` at 0.
- R9: Pause computes e = now_i - launch time. If the corrected delay is greater than e, it is reduced by e and the remaining time is rearmed on resume. Otherwise the delay is dropped, `busy_o` falls and no completion occurs.
- R10: A request while a delay is pending replaces it; timing restarts from the new request's edge.
- R11: Cancel drops the pending delay: `busy_o`, `armed_o` and `cmp_target_o` go to 0 and no completion follows.
- R12: The comparator uses wrap-safe comparison, so a delay whose target wraps past 2^TW-1 completes after the same interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| now_i | input | TW | Free-running microsecond reference |
| run_start_i | input | 1 | Resume the time base (pulse) |
| run_stop_i | input | 1 | Pause the time base (pulse) |
| rel_req_i | input | 1 | Request a relative delay of `req_val_i` (pulse) |
| abs_req_i | input | 1 | Request completion at absolute time `req_val_i` (pulse) |
| req_val_i | input | TW | Delay or absolute target |
| cancel_i | input | 1 | Drop the pending delay (pulse) |
| fire_o | output | 1 | Completion pulse |
| busy_o | output | 1 | A delay is pending |
| armed_o | output | 1 | Comparator is armed |
| cmp_target_o | output | TW | Current comparator target |

## Verification
Commands take effect at the edge that samples them, and their status is visible one cycle later. For a request sampled while `now_i` = N0, with total armed time T, `fire_o` is first high when `now_i` = N0+T+1. The bench drives `now_i` as a counter that advances on each edge and records its value at the request edge. It then samples at falling edges and compares the value of `now_i` when `fire_o` first appears against that formula. It also confirms that the pulse is gone one cycle later, and that no pulse appears early or in any window where none is due.

// File: rtl/dly_sched_pkg.sv
package dly_sched_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_CANCEL,
    CMD_STOP,
    CMD_START,
    CMD_REL,
    CMD_ABS,
    CMD_HIT
  } dly_cmd_e;
endpackage

// File: rtl/dly_split.sv
module dly_split #(
  parameter int TW   = 32,
  parameter int CW   = 24,
  parameter int CORR = 2
) (
  input  logic [TW-1:0]    raw_i,
  input  logic             corr_en_i,
  output logic [TW-1:0]    delta_o,
  output logic [TW-CW-1:0] chunks_o,
  output logic [CW-1:0]    rem_o
);
  localparam logic [TW-1:0] CORR_V = TW'(CORR);

  logic [TW-1:0] corrected;

  always_comb begin
    corrected = (raw_i > CORR_V) ? (raw_i - CORR_V) : '0;
    delta_o   = corr_en_i ? corrected : raw_i;
    chunks_o  = delta_o[TW-1:CW];
    rem_o     = delta_o[CW-1:0];
  end
endmodule

// File: rtl/dly_step.sv
module dly_step #(
  parameter int TW     = 32,
  parameter int CW     = 24,
  parameter int MIN_IV = 5
) (
  input  logic             launch_i,
  input  logic [TW-CW-1:0] chunks_i,
  input  logic [CW-1:0]    rem_i,
  output logic [CW-1:0]    interval_o,
  output logic [TW-CW-1:0] chunks_o,
  output logic [CW-1:0]    rem_o,
  output logic             done_o
);
  localparam int            CKW  = TW - CW;
  localparam logic [CW-1:0] MAXV = '1;
  localparam logic [CW-1:0] MINV = CW'(MIN_IV);

  logic rem_ok;

  always_comb begin
    rem_ok     = launch_i ? (rem_i > MINV) : (rem_i >= MINV);
    interval_o = MINV;
    chunks_o   = chunks_i;
    rem_o      = rem_i;
    done_o     = 1'b0;
    if (chunks_i != '0) begin
      chunks_o   = chunks_i - CKW'(1);
      interval_o = MAXV;
    end else if (rem_ok) begin
      interval_o = rem_i;
      rem_o      = '0;
    end else begin
      rem_o  = '0;
      done_o = !launch_i;
    end
  end
endmodule

// File: rtl/dly_cmp.sv
module dly_cmp #(
  parameter int TW = 32,
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] now_i,
  input  logic          load_i,
  input  logic [CW-1:0] interval_i,
  input  logic          clr_i,
  output logic          armed_o,
  output logic [TW-1:0] target_o,
  output logic          hit_o
);
  logic          armed_q, armed_d;
  logic [TW-1:0] target_q, target_d;
  logic [TW-1:0] diff;
  logic          en;

  always_comb begin
    en       = load_i | clr_i;
    armed_d  = armed_q;
    target_d = target_q;
    if (clr_i) begin
      armed_d  = 1'b0;
      target_d = '0;
    end else if (load_i) begin
      armed_d  = 1'b1;
      target_d = now_i + {{(TW-CW){1'b0}}, interval_i};
    end
    diff  = now_i - target_q;
    hit_o = armed_q && !diff[TW-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      target_q <= '0;
    end else if (en) begin
      armed_q  <= armed_d;
      target_q <= target_d;
    end
  end

  assign armed_o  = armed_q;
  assign target_o = target_q;

  // R12
  hold_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_i) |=> $stable(target_q));

  // R6
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (target_q == '0) && !armed_q);
endmodule

// File: rtl/dly_sched.sv
module dly_sched #(
  parameter int TW     = 32,
  parameter int CW     = 24,
  parameter int MIN_IV = 5,
  parameter int CORR   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] now_i,
  input  logic          run_start_i,
  input  logic          run_stop_i,
  input  logic          rel_req_i,
  input  logic          abs_req_i,
  input  logic [TW-1:0] req_val_i,
  input  logic          cancel_i,
  output logic          fire_o,
  output logic          busy_o,
  output logic          armed_o,
  output logic [TW-1:0] cmp_target_o
);
  import dly_sched_pkg::*;

  localparam int CKW = TW - CW;

  logic           run_q, run_d;
  logic           used_q, used_d;
  logic           fire_q, fire_d;
  logic [TW-1:0]  delta_q, delta_d;
  logic [TW-1:0]  start_q, start_d;
  logic [CKW-1:0] chunks_q, chunks_d;
  logic [CW-1:0]  rem_q, rem_d;

  dly_cmd_e       cmd;
  logic           hit;
  logic [TW-1:0]  split_in, split_delta, elapsed;
  logic           split_corr;
  logic [CKW-1:0] split_chunks, step_chunks_in, step_chunks;
  logic [CW-1:0]  split_rem, step_rem_in, step_rem, step_iv;
  logic           step_launch, step_done;
  logic           cmp_load, cmp_clr;

  // command priority
  always_comb begin
    if (cancel_i)         cmd = CMD_CANCEL;
    else if (run_stop_i)  cmd = CMD_STOP;
    else if (run_start_i) cmd = CMD_START;
    else if (rel_req_i)   cmd = CMD_REL;
    else if (abs_req_i)   cmd = CMD_ABS;
    else if (hit)         cmd = CMD_HIT;
    else                  cmd = CMD_NONE;
  end

  always_comb begin
    split_corr     = (cmd == CMD_REL) || (cmd == CMD_ABS);
    split_in       = (cmd == CMD_START) ? delta_q :
                     (cmd == CMD_ABS)   ? (req_val_i - now_i) : req_val_i;
    step_launch    = (cmd != CMD_HIT);
    step_chunks_in = step_launch ? split_chunks : chunks_q;
    step_rem_in    = step_launch ? split_rem    : rem_q;
    elapsed        = now_i - start_q;
  end

  dly_split #(.TW(TW), .CW(CW), .CORR(CORR)) u_split (
    .raw_i     (split_in),
    .corr_en_i (split_corr),
    .delta_o   (split_delta),
    .chunks_o  (split_chunks),
    .rem_o     (split_rem)
  );

  dly_step #(.TW(TW), .CW(CW), .MIN_IV(MIN_IV)) u_step (
    .launch_i   (step_launch),
    .chunks_i   (step_chunks_in),
    .rem_i      (step_rem_in),
    .interval_o (step_iv),
    .chunks_o   (step_chunks),
    .rem_o      (step_rem),
    .done_o     (step_done)
  );

  dly_cmp #(.TW(TW), .CW(CW)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .now_i      (now_i),
    .load_i     (cmp_load),
    .interval_i (step_iv),
    .clr_i      (cmp_clr),
    .armed_o    (armed_o),
    .target_o   (cmp_target_o),
    .hit_o      (hit)
  );

  // next state
  always_comb begin
    run_d    = run_q;
    used_d   = used_q;
    fire_d   = 1'b0;
    delta_d  = delta_q;
    start_d  = start_q;
    chunks_d = chunks_q;
    rem_d    = rem_q;
    cmp_load = 1'b0;
    cmp_clr  = 1'b0;
    unique case (cmd)
      CMD_CANCEL: begin
        used_d   = 1'b0;
        cmp_clr  = 1'b1;
        chunks_d = '0;
        rem_d    = '0;
      end
      CMD_STOP: begin
        run_d = 1'b0;
        if (used_q && run_q) begin
          cmp_clr = 1'b1;
          if (delta_q > elapsed) delta_d = delta_q - elapsed;
          else                   used_d  = 1'b0;
        end
      end
      CMD_START: begin
        run_d = 1'b1;
        if (used_q && !run_q) begin
          start_d  = now_i;
          chunks_d = step_chunks;
          rem_d    = step_rem;
          cmp_load = 1'b1;
        end
      end
      CMD_REL, CMD_ABS: begin
        used_d  = 1'b1;
        delta_d = split_delta;
        if (run_q) begin
          start_d  = now_i;
          chunks_d = step_chunks;
          rem_d    = step_rem;
          cmp_load = 1'b1;
        end else begin
          cmp_clr = 1'b1;
        end
      end
      CMD_HIT: begin
        chunks_d = step_chunks;
        rem_d    = step_rem;
        if (step_done) begin
          used_d  = 1'b0;
          fire_d  = 1'b1;
          cmp_clr = 1'b1;
        end else begin
          cmp_load = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      used_q   <= 1'b0;
      fire_q   <= 1'b0;
      delta_q  <= '0;
      start_q  <= '0;
      chunks_q <= '0;
      rem_q    <= '0;
    end else begin
      run_q    <= run_d;
      used_q   <= used_d;
      fire_q   <= fire_d;
      delta_q  <= delta_d;
      start_q  <= start_d;
      chunks_q <= chunks_d;
      rem_q    <= rem_d;
    end
  end

  assign fire_o = fire_q;
  assign busy_o = used_q;

  // R6
  fire_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

  // R6
  fire_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (!busy_o && !armed_o));

  // R8
  arm_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |-> (busy_o && run_q));

  // R11
  cancel_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> (!busy_o && !armed_o && !fire_o));

  // R9
  stop_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_stop_i && !cancel_i) |=> !armed_o);
endmodule

// File: tb/dly_sched_tb.sv
module dly_sched_tb;
  localparam int TW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [TW-1:0] now;
  logic          now_ld;
  logic [TW-1:0] now_ldv;
  logic          run_start, run_stop, rel_req, abs_req, cancel;
  logic [TW-1:0] req_val;
  logic          fire, busy, armed;
  logic [TW-1:0] target;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n)      now <= 32'd100;
    else if (now_ld) now <= now_ldv;
    else             now <= now + 32'd1;
  end

  dly_sched #(.TW(TW), .CW(CW), .MIN_IV(5), .CORR(2)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .now_i        (now),
    .run_start_i  (run_start),
    .run_stop_i   (run_stop),
    .rel_req_i    (rel_req),
    .abs_req_i    (abs_req),
    .req_val_i    (req_val),
    .cancel_i     (cancel),
    .fire_o       (fire),
    .busy_o       (busy),
    .armed_o      (armed),
    .cmp_target_o (target)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    run_start = 1'b1; @(negedge clk); run_start = 1'b0;
  endtask

  task automatic pulse_stop();
    run_stop = 1'b1; @(negedge clk); run_stop = 1'b0;
  endtask

  task automatic issue_rel(input logic [TW-1:0] d, output logic [TW-1:0] n0);
    n0 = now; req_val = d; rel_req = 1'b1;
    @(negedge clk); rel_req = 1'b0;
  endtask

  // wait for the first completion pulse and compare the time it shows up
  task automatic wait_fire(input logic [TW-1:0] exp_now, input string tag);
    int n = 0;
    while (!fire && n < 300) begin @(negedge clk); n++; end
    chk(fire && now == exp_now, tag, now, exp_now);
    chk(!busy && !armed && target == '0, {tag, " idle at fire"}, {busy, armed}, 0);
    @(negedge clk);
    chk(!fire, {tag, " one-cycle pulse"}, fire, 0);
  endtask

  task automatic no_fire(input int cyc, input string tag);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (fire) seen++; end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic t_reset();
    chk(!fire && !busy && !armed && target == '0, "R1 reset state", {fire, busy, armed}, 0);
    pulse_start();
    chk(!armed && !busy, "R8 start with nothing pending", armed, 0);
  endtask

  task automatic t_min_rules();
    logic [TW-1:0] n0;
    issue_rel(32'd1, n0); wait_fire(n0 + 32'd6, "R2 R5 floor to zero -> MIN");
    issue_rel(32'd9, n0); wait_fire(n0 + 32'd8, "R2 R5 remainder above MIN");
    issue_rel(32'd7, n0); wait_fire(n0 + 32'd6, "R5 remainder equal MIN");
  endtask

  task automatic t_chunks();
    logic [TW-1:0] n0;
    issue_rel(32'd40, n0); wait_fire(n0 + 32'd37, "R3 two chunks plus remainder");
    issue_rel(32'd23, n0); wait_fire(n0 + 32'd21, "R4 remainder equal MIN after chunk");
    issue_rel(32'd37, n0); wait_fire(n0 + 32'd31, "R4 small remainder dropped");
  endtask

  task automatic t_abs();
    logic [TW-1:0] n0;
    n0 = now; req_val = now + 32'd20; abs_req = 1'b1;
    @(negedge clk); abs_req = 1'b0;
    wait_fire(n0 + 32'd16, "R7 absolute target");
  endtask

  task automatic t_replace();
    logic [TW-1:0] n0, n1;
    issue_rel(32'd40, n0);
    repeat (9) @(negedge clk);
    issue_rel(32'd9, n1);
    wait_fire(n1 + 32'd8, "R10 replaced request");
  endtask

  task automatic t_cancel();
    logic [TW-1:0] n0;
    issue_rel(32'd40, n0);
    repeat (5) @(negedge clk);
    cancel = 1'b1; @(negedge clk); cancel = 1'b0;
    chk(!busy && !armed && target == '0, "R11 cancel clears", {busy, armed}, 0);
    no_fire(50, "R11 no fire after cancel");
  endtask

  task automatic t_stop_resume();
    logic [TW-1:0] n0, n1;
    issue_rel(32'd102, n0);
    repeat (39) @(negedge clk);
    run_stop = 1'b1; @(negedge clk); run_stop = 1'b0;
    chk(busy && !armed, "R9 paused keeps delay", {busy, armed}, 2);
    n1 = now; run_start = 1'b1; @(negedge clk); run_start = 1'b0;
    wait_fire(n1 + 32'd58, "R9 resume with remaining time");
  endtask

  task automatic t_stop_drop();
    logic [TW-1:0] n0;
    issue_rel(32'd5, n0);
    repeat (3) @(negedge clk);
    pulse_stop();
    chk(!busy && !armed, "R9 elapsed covers delay -> dropped", {busy, armed}, 0);
    pulse_start();
    no_fire(20, "R9 dropped delay never fires");
  endtask

  task automatic t_held();
    logic [TW-1:0] n0, n1;
    pulse_stop();
    issue_rel(32'd9, n0);
    chk(busy && !armed, "R8 request held while paused", {busy, armed}, 2);
    no_fire(15, "R8 no fire while paused");
    n1 = now; pulse_start();
    wait_fire(n1 + 32'd8, "R8 timing from resume");
  endtask

  task automatic t_wrap();
    logic [TW-1:0] n0;
    now_ldv = 32'hFFFF_FFF8; now_ld = 1'b1; @(negedge clk); now_ld = 1'b0;
    issue_rel(32'd40, n0);
    wait_fire(n0 + 32'd37, "R12 wrap across 2^32");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; now_ld = 1'b0; now_ldv = '0;
    run_start = 1'b0; run_stop = 1'b0; rel_req = 1'b0; abs_req = 1'b0;
    cancel = 1'b0; req_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_min_rules();
    t_chunks();
    t_abs();
    t_replace();
    t_cancel();
    t_stop_resume();
    t_stop_drop();
    t_held();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule